// File: doc/BRIEF.md
# Reset Sequencer with Source Classification

This block gathers the reset requests of a chip and turns them into one timed sequence on a shared, open-drain reset pin. The requests come from power-on, low-voltage, illegal address, clock monitor and watchdog detectors, and from the pin itself. When a request is seen, the block pulls the pin low for a fixed number of clocks and then lets it go. It waits a further settling interval and then reads the pin. If something outside is still holding the pin low, the reset is treated as external.

The result is a one-hot source code that the core uses to select its reset vector. A core reset stays asserted from detection until that code is latched. The watchdog and clock-monitor requests each pass through a local enable. The other requests are always armed. `pin_i` is the pin level and is assumed to be already synchronous to `clk_i`.

Top module: `rstgen_top`

## Requirements
- R1: While `rst_ni` is low, `pin_drive_low_o` and `core_rst_o` are 1 and `src_code_o` is 0. After `rst_ni` rises, a power-on sequence runs by itself and ends with code `6'b000001`.
- R2: In idle, an enabled internal request, or `pin_i` low, starts a sequence. `pin_drive_low_o` is then 1 for exactly DRIVE_CYC (512) clocks.
- R3: After the drive ends, `core_rst_o` stays 1 with the pin released for exactly WAIT_CYC (256) clocks. On the edge that closes the wait, the pin is sampled, the code is latched and `core_rst_o` falls.
- R4: If `pin_i` is low at the sample, source bit 2 (external) is set, unless a power-on or low-voltage request is pending.
- R5: The code is one-hot: bit0 power-on, bit1 low-voltage, bit2 external, bit3 illegal address, bit4 clock monitor, bit5 watchdog. When several are pending, the lowest bit index wins.
- R6: A watchdog request with `wdog_en_i`=0, or a clock-monitor request with `clkmon_en_i`=0, starts no sequence and leaves the code unchanged.
- R7: An enabled internal request during the drive or wait phase restarts the DRIVE_CYC count. It also adds to the pending sources.
- R8: `src_code_o` changes only on the edge that closes a wait phase, and holds otherwise.
- R9: `core_rst_o` is 1 whenever `pin_drive_low_o` is 1, and through the whole wait.
- R10: A sequence started by the pin is classed external even if the pin has gone high again by the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PLL-domain clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| por_req_i | input | 1 | Power-on request |
| lvr_req_i | input | 1 | Low-voltage request |
| ill_addr_req_i | input | 1 | Illegal address request |
| clkmon_fail_i | input | 1 | Clock monitor failure |
| clkmon_en_i | input | 1 | Local enable for clock monitor |
| wdog_req_i | input | 1 | Watchdog timeout |
| wdog_en_i | input | 1 | Local enable for watchdog |
| pin_i | input | 1 | Reset pin level (1 = high) |
| pin_drive_low_o | output | 1 | 1 pulls the reset pin low |
| core_rst_o | output | 1 | Core reset, active high |
| src_code_o | output | 6 | One-hot latched reset source |

## Verification
A counter that wraps at the wrong value, or a phase state that skips a step, shows up at the pins as a drive pulse or wait interval of the wrong length. That error appears within the first sequence, at most 768 clocks after detection. A wrong pending-source record or priority choice stays hidden until `core_rst_o` falls, and then it shows up as a wrong one-hot code. A missed restart shows up as a drive pulse that ends early, measured from the interrupting request.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int SRC_N   = 6;
  localparam int SRC_POR = 0;
  localparam int SRC_LVR = 1;
  localparam int SRC_EXT = 2;
  localparam int SRC_ILL = 3;
  localparam int SRC_CLK = 4;
  localparam int SRC_WDG = 5;

  typedef logic [SRC_N-1:0] src_vec_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2
  } rst_state_e;
endpackage

// File: rtl/rstgen_req.sv
module rstgen_req
  import rstgen_pkg::*;
(
  input  logic     por_i,
  input  logic     lvr_i,
  input  logic     ill_i,
  input  logic     clkmon_i,
  input  logic     clkmon_en_i,
  input  logic     wdog_i,
  input  logic     wdog_en_i,
  output src_vec_t req_o
);
  always_comb begin
    req_o          = '0;
    req_o[SRC_POR] = por_i;
    req_o[SRC_LVR] = lvr_i;
    req_o[SRC_ILL] = ill_i;
    req_o[SRC_CLK] = clkmon_i & clkmon_en_i;
    req_o[SRC_WDG] = wdog_i & wdog_en_i;
  end
endmodule

// File: rtl/rstgen_prio.sv
module rstgen_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] grant_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  // lowest index has highest priority
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | sel_i[i];
    assign grant_o[i]   = sel_i[i] & ~blocked[i];
  end

  always_comb begin
    p_grant_subset_r5: assert ((grant_o & ~sel_i) == '0 && $onehot0(grant_o));
  end
endmodule

// File: rtl/rstgen_seq.sv
module rstgen_seq
  import rstgen_pkg::*;
#(
  parameter int DRIVE_CYC = 512,
  parameter int WAIT_CYC  = 256
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t req_i,
  input  logic     pin_i,
  output logic     pin_drive_low_o,
  output logic     core_rst_o,
  output src_vec_t src_code_o
);
  localparam int CNT_MAX = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_CYC - 1);

  rst_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  src_vec_t         pend_q, pend_d, code_q, code_d;
  src_vec_t         ext_vec, grant;
  logic             int_req;

  assign int_req = |req_i;

  always_comb begin
    ext_vec          = '0;
    ext_vec[SRC_EXT] = ~pin_i;
  end

  rstgen_prio #(.N(SRC_N)) u_prio (
    .sel_i   (pend_q | ext_vec),
    .grant_o (grant)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    code_d  = code_q;
    unique case (state_q)
      ST_IDLE: begin
        if (int_req || !pin_i) begin
          state_d = ST_DRIVE;
          cnt_d   = '0;
          pend_d  = req_i | ext_vec;
        end
      end
      ST_DRIVE: begin
        if (int_req) begin
          cnt_d  = '0;
          pend_d = pend_q | req_i;
        end else if (cnt_q == DRIVE_LAST) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (int_req) begin
          state_d = ST_DRIVE;
          cnt_d   = '0;
          pend_d  = pend_q | req_i;
        end else if (cnt_q == WAIT_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          code_d  = grant;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register reset enters the power-on sequence directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_DRIVE;
      cnt_q           <= '0;
      pend_q          <= '0;
      pend_q[SRC_POR] <= 1'b1;
      code_q          <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      code_q  <= code_d;
    end
  end

  assign pin_drive_low_o = (state_q == ST_DRIVE);
  assign core_rst_o      = (state_q != ST_IDLE);
  assign src_code_o      = code_q;

  p_drive_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_low_o) |-> $past(cnt_q) == DRIVE_LAST);

  p_latch_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> ($past(state_q) == ST_WAIT && $past(cnt_q) == WAIT_LAST));

  p_code_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_code_o));

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && int_req) |=> (state_q == ST_DRIVE && cnt_q == '0));

  p_code_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_WAIT) |=> $stable(src_code_o));

  p_core_cover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_low_o |-> core_rst_o);
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int DRIVE_CYC = 512,
  parameter int WAIT_CYC  = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_req_i,
  input  logic       lvr_req_i,
  input  logic       ill_addr_req_i,
  input  logic       clkmon_fail_i,
  input  logic       clkmon_en_i,
  input  logic       wdog_req_i,
  input  logic       wdog_en_i,
  input  logic       pin_i,
  output logic       pin_drive_low_o,
  output logic       core_rst_o,
  output logic [5:0] src_code_o
);
  src_vec_t req;

  rstgen_req u_req (
    .por_i       (por_req_i),
    .lvr_i       (lvr_req_i),
    .ill_i       (ill_addr_req_i),
    .clkmon_i    (clkmon_fail_i),
    .clkmon_en_i (clkmon_en_i),
    .wdog_i      (wdog_req_i),
    .wdog_en_i   (wdog_en_i),
    .req_o       (req)
  );

  rstgen_seq #(.DRIVE_CYC(DRIVE_CYC), .WAIT_CYC(WAIT_CYC)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_i           (req),
    .pin_i           (pin_i),
    .pin_drive_low_o (pin_drive_low_o),
    .core_rst_o      (core_rst_o),
    .src_code_o      (src_code_o)
  );
endmodule

// File: tb/rstgen_top_tb_top.sv
module rstgen_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 0, lvr = 0, ill = 0, clkf = 0, clk_en = 0, wd = 0, wd_en = 0;
  logic ext_low = 0;
  logic pin, drive, core_rst;
  logic [5:0] code;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // open-drain pin with pull-up
  assign pin = ~(drive | ext_low);

  rstgen_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_req_i(por), .lvr_req_i(lvr),
    .ill_addr_req_i(ill), .clkmon_fail_i(clkf), .clkmon_en_i(clk_en),
    .wdog_req_i(wd), .wdog_en_i(wd_en), .pin_i(pin),
    .pin_drive_low_o(drive), .core_rst_o(core_rst), .src_code_o(code)
  );

  // {por,lvr,ill,clkmon,wdog, clk_en,wd_en,ext_hold, 2'b0, expected code}
  localparam int NV = 12;
  localparam logic [15:0] VECS [NV] = '{
    {5'b10000, 3'b000, 2'b00, 6'b000001},
    {5'b01000, 3'b000, 2'b00, 6'b000010},
    {5'b00100, 3'b000, 2'b00, 6'b001000},
    {5'b00010, 3'b100, 2'b00, 6'b010000},
    {5'b00001, 3'b010, 2'b00, 6'b100000},
    {5'b00101, 3'b010, 2'b00, 6'b001000},
    {5'b00011, 3'b110, 2'b00, 6'b010000},
    {5'b01100, 3'b001, 2'b00, 6'b000010},
    {5'b00100, 3'b001, 2'b00, 6'b000100},
    {5'b10000, 3'b001, 2'b00, 6'b000001},
    {5'b00001, 3'b011, 2'b00, 6'b000100},
    {5'b00000, 3'b001, 2'b00, 6'b000100}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // call at a negedge where drive is already high
  task automatic measure(output int nd, output int nw);
    nd = 0; nw = 0;
    while (drive) begin nd++; @(negedge clk); end
    while (core_rst && !drive) begin nw++; @(negedge clk); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  initial begin
    int nd, nw;
    logic [5:0] held;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(drive == 1 && core_rst == 1 && code == 0, "R1 reset outputs",
        {drive, core_rst, code}, 8'hC0);
    rst_n = 1;
    @(negedge clk);
    measure(nd, nw);
    chk(nw == 256, "R1 power-up wait", nw, 256);
    chk(code == 6'b000001, "R1 power-up code", code, 1);
    repeat (3) @(negedge clk);

    // vector table: R2 drive length, R3 wait length, R4/R5 code
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VECS[i];
      {clk_en, wd_en} = v[10:9];
      {por, lvr, ill, clkf, wd} = v[15:11];
      ext_low = v[8];
      @(negedge clk);
      {por, lvr, ill, clkf, wd} = '0;
      measure(nd, nw);
      ext_low = 0;
      chk(nd == 512, $sformatf("R2 drive len vec %0d", i), nd, 512);
      chk(nw == 256, $sformatf("R3 R9 wait len vec %0d", i), nw, 256);
      chk(code == v[5:0], $sformatf("R5 R4 code vec %0d", i), code, v[5:0]);
      repeat (3) @(negedge clk);
    end

    // R6 disabled requests ignored
    clk_en = 0; wd_en = 0; held = code;
    clkf = 1; wd = 1;
    @(negedge clk);
    clkf = 0; wd = 0;
    repeat (4) @(negedge clk);
    chk(core_rst == 0 && drive == 0, "R6 no sequence", {core_rst, drive}, 0);
    chk(code == held, "R6 code unchanged", code, held);

    // R8 code holds in idle
    repeat (40) @(negedge clk);
    chk(code == held, "R8 code hold", code, held);

    // R10 short external pulse
    ext_low = 1;
    @(negedge clk);
    ext_low = 0;
    measure(nd, nw);
    chk(nd == 512, "R10 drive len", nd, 512);
    chk(code == 6'b000100, "R10 external code", code, 4);
    repeat (3) @(negedge clk);

    // R7 restart during drive
    ill = 1;
    @(negedge clk);
    ill = 0;
    nd = 0;
    while (drive) begin
      nd++;
      if (nd == 300) begin wd_en = 1; wd = 1; end
      @(negedge clk);
      wd = 0;
    end
    chk(nd == 812, "R7 drive restart len", nd, 812);
    nw = 0;
    while (core_rst && !drive) begin nw++; @(negedge clk); end
    chk(code == 6'b001000, "R7 pending merge code", code, 8);
    repeat (3) @(negedge clk);

    // R7 restart during wait
    lvr = 1;
    @(negedge clk);
    lvr = 0;
    while (drive) @(negedge clk);
    for (int k = 1; k < 100; k++) @(negedge clk);
    clk_en = 1; clkf = 1;
    @(negedge clk);
    clkf = 0;
    chk(drive == 1, "R7 wait restart drive", drive, 1);
    measure(nd, nw);
    chk(nd == 512, "R7 redrive len", nd, 512);
    chk(nw == 256, "R7 rewait len", nw, 256);
    chk(code == 6'b000010, "R7 R5 priority code", code, 2);

    done = 1;
    finish_run();
  end
endmodule